// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block derives two frame-synchronisation strobes from one sync clock. The fast strobe repeats once per short frame (8 kHz at the intended clock). The slow strobe repeats once per superframe of four short frames (2 kHz). At its intended 19.44 MHz clock the short frame lasts 2430 cycles and the superframe 9720 cycles. The superframe's first cycle is always the first cycle of a short frame, so the slow strobe rises together with every fourth rise of the fast strobe.

Each strobe is either a square wave high for half its period, or a narrow pulse. A narrow pulse is high for a programmed number of sync-clock periods, from 1 to 15. A single narrow width is shared by both strobes. Software programs two byte-wide registers through a plain write strobe with an address. A 2-bit mode field picks the shape of each strobe, and a 4-bit field holds the width.

Written values are held pending. They reach the strobes only at the end of a superframe, so a change never cuts short or stretches a pulse already in progress.

Top module: `fsync_pulse_gen`

## Requirements
- R1: A synchronous active-high reset clears both frame counters and drives both outputs low. After reset, the mode is 00 (both square) and the width is 1. On the first clock after reset is released, both outputs go high, because that cycle starts a superframe.
- R2: In square mode the fast output has a period of FRAME_CYCLES and is high for the first FRAME_CYCLES/2 cycles of each period.
- R3: In square mode the slow output has a period of 4*FRAME_CYCLES and is high for the first 2*FRAME_CYCLES cycles of each period.
- R4: Every rising edge of the slow output falls in the same cycle as a rising edge of the fast output, and this happens on every fourth fast rising edge.
- R5: A write with wr_addr = CTRL_ADDR (default 0x04) loads the mode field from wr_data[5:4]. Bit 4 set makes the fast output narrow and bit 5 set makes the slow output narrow, so 00 = both square, 01 = fast narrow, 10 = slow narrow, 11 = both narrow.
- R6: A write with wr_addr = WIDTH_ADDR (default 0x10) loads the width from wr_data[3:0]. A narrow output is high for exactly that many cycles at the start of each of its own periods, and the same width applies to both outputs.
- R7: A width value of 0 behaves exactly like a width value of 1.
- R8: New mode and width values take effect only from the first cycle of the next superframe. The outputs keep the previous settings until then.
- R9: A write to any other address changes neither output, and neither does a cycle with wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register write address |
| wr_data | input | DATA_W (8) | Register write data |
| sync_fast_o | output | 1 | Short-frame strobe (8 kHz) |
| sync_slow_o | output | 1 | Superframe strobe (2 kHz) |

## Verification
The bench builds the block with FRAME_CYCLES = 20, which gives an 80-cycle superframe, and keeps every other parameter at its default. The short frame brings many superframe boundaries within a run of a few hundred cycles. Every mode code, the width extremes 0, 1 and 15, and writes landing in the middle of a superframe can therefore each be followed across the boundary where they take effect. A width of 15 still ends well inside the 20-cycle frame, so a narrow pulse and the square wave stay clearly distinct.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  // Index of each strobe inside the per-output arrays; it matches the mode bit
  localparam int unsigned OUT_FAST = 0;
  localparam int unsigned OUT_SLOW = 1;
  localparam int unsigned N_OUTS   = 2;

  // Frames per superframe (slow period in fast frames)
  localparam int unsigned FRAMES_PER_SUPER = 4;

  // Mode field location inside the control register
  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned MODE_W   = 2;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_RESET = 2'b00;

endpackage

// File: rtl/fsync_frame_ctr.sv
module fsync_frame_ctr #(
  parameter int unsigned FRAME_CYCLES = 2430,
  parameter int unsigned SUPER_CYCLES = 9720,
  parameter int unsigned PW           = 14
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] fast_phase,
  output logic [PW-1:0] slow_phase,
  output logic          super_last
);

  localparam logic [PW-1:0] ONE       = PW'(1);
  localparam logic [PW-1:0] FAST_LAST = PW'(FRAME_CYCLES - 1);
  localparam logic [PW-1:0] SLOW_LAST = PW'(SUPER_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_phase <= '0;
      slow_phase <= '0;
    end else begin
      fast_phase <= (fast_phase == FAST_LAST) ? '0 : fast_phase + ONE;
      slow_phase <= (slow_phase == SLOW_LAST) ? '0 : slow_phase + ONE;
    end
  end

  assign super_last = (slow_phase == SLOW_LAST);

  AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (slow_phase == '0) |-> (fast_phase == '0)); // R4

  AST_FAST_RANGE: assert property (@(posedge clk) disable iff (rst)
    fast_phase <= FAST_LAST); // R2

endmodule

// File: rtl/fsync_cfg_regs.sv
module fsync_cfg_regs
  import fsync_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WID_W      = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 5'h04,
  parameter logic [ADDR_W-1:0] WIDTH_ADDR = 5'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              apply,
  output mode_t             act_mode,
  output logic [WID_W-1:0]  act_width
);

  localparam logic [WID_W-1:0] WID_ONE = WID_W'(1);

  mode_t             pend_mode;
  logic [WID_W-1:0]  pend_width;

  // Pending copies follow software writes at once
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode  <= MODE_RESET;
      pend_width <= WID_ONE;
    end else if (wr_en) begin
      if (wr_addr == CTRL_ADDR)
        pend_mode <= wr_data[MODE_LSB +: MODE_W];
      if (wr_addr == WIDTH_ADDR)
        pend_width <= wr_data[WID_W-1:0];
    end
  end

  // Active copies move only at the superframe boundary; zero width folds to one
  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode  <= MODE_RESET;
      act_width <= WID_ONE;
    end else if (apply) begin
      act_mode  <= pend_mode;
      act_width <= (pend_width == '0) ? WID_ONE : pend_width;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(apply) |-> ($stable(act_mode) && $stable(act_width))); // R8

  AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (rst)
    act_width != '0); // R7

endmodule

// File: rtl/fsync_shaper.sv
module fsync_shaper #(
  parameter int unsigned PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase,
  input  logic [PW-1:0] high_len,
  output logic          pulse_o
);

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= (phase < high_len);
  end

  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |=> pulse_o); // R6

endmodule

// File: rtl/fsync_pulse_gen.sv
module fsync_pulse_gen
  import fsync_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = 2430,
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned WID_W        = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 5'h04,
  parameter logic [ADDR_W-1:0] WIDTH_ADDR = 5'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sync_fast_o,
  output logic              sync_slow_o
);

  localparam int unsigned SUPER_CYCLES = FRAME_CYCLES * FRAMES_PER_SUPER;
  localparam int unsigned PW           = $clog2(SUPER_CYCLES);

  logic [PW-1:0]    fast_phase, slow_phase;
  logic             super_last;
  mode_t            act_mode;
  logic [WID_W-1:0] act_width;
  logic [PW-1:0]    width_ext;
  logic [PW-1:0]    phase_arr [N_OUTS];
  logic [N_OUTS-1:0] pulse_arr;

  fsync_frame_ctr #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .SUPER_CYCLES(SUPER_CYCLES),
    .PW(PW)
  ) ctr_i (
    .clk(clk), .rst(rst),
    .fast_phase(fast_phase), .slow_phase(slow_phase),
    .super_last(super_last)
  );

  fsync_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WID_W(WID_W),
    .CTRL_ADDR(CTRL_ADDR), .WIDTH_ADDR(WIDTH_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .apply(super_last),
    .act_mode(act_mode), .act_width(act_width)
  );

  assign width_ext           = PW'(act_width);
  assign phase_arr[OUT_FAST] = fast_phase;
  assign phase_arr[OUT_SLOW] = slow_phase;

  for (genvar g = 0; g < N_OUTS; g++) begin : g_out
    localparam int unsigned PERIOD = (g == OUT_FAST) ? FRAME_CYCLES : SUPER_CYCLES;
    localparam logic [PW-1:0] HALF = PW'(PERIOD / 2);
    logic [PW-1:0] high_len;

    assign high_len = act_mode[g] ? width_ext : HALF;

    fsync_shaper #(.PW(PW)) shp_i (
      .clk(clk), .rst(rst),
      .phase(phase_arr[g]), .high_len(high_len),
      .pulse_o(pulse_arr[g])
    );
  end

  assign sync_fast_o = pulse_arr[OUT_FAST];
  assign sync_slow_o = pulse_arr[OUT_SLOW];

  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) |-> (!sync_fast_o && !sync_slow_o)); // R1

  AST_SLOW_RISE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_slow_o) |-> $rose(sync_fast_o)); // R4

endmodule

// File: tb/fsync_pulse_gen_tb.sv
module fsync_pulse_gen_tb_top;

  localparam int unsigned F = 20;
  localparam int unsigned S = F * 4;
  localparam logic [4:0] A_CTRL  = 5'h04;
  localparam logic [4:0] A_WIDTH = 5'h10;

  typedef struct {
    bit    fast;
    bit    slow;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sync_fast_o, sync_slow_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t exp_q[$];
  bit   done = 1'b0;

  // Bench model of the configuration and phase
  int m_phase;
  int m_act_mode, m_act_w, m_pend_mode, m_pend_w;
  bit m_live;

  always #4 clk = ~clk;

  fsync_pulse_gen #(.FRAME_CYCLES(F)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_fast_o(sync_fast_o), .sync_slow_o(sync_slow_o)
  );

  function automatic int eff(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  task automatic model_reset();
    m_phase = 0; m_act_mode = 0; m_act_w = 1; m_pend_mode = 0; m_pend_w = 1;
  endtask

  // One clock: drive inputs, queue the output expected after the next edge
  task automatic tick(input bit we, input logic [4:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    int   fh, sh;
    @(posedge clk); #2;
    wr_en = we; wr_addr = a; wr_data = d;
    fh = (m_act_mode & 1) ? m_act_w : F / 2;
    sh = (m_act_mode & 2) ? m_act_w : S / 2;
    e.fast = ((m_phase % F) < fh);
    e.slow = (m_phase < sh);
    e.tag  = tag;
    exp_q.push_back(e);
    if (m_phase == S - 1) begin
      m_act_mode = m_pend_mode;
      m_act_w    = eff(m_pend_w);
    end
    if (we && a == A_CTRL)  m_pend_mode = (d >> 4) & 3;
    if (we && a == A_WIDTH) m_pend_w    = d & 15;
    m_phase = (m_phase + 1) % S;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 5'h00, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1'b1; wr_en = 1'b0;
    m_live = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    exp_q.delete();
    n_tests++;
    if (sync_fast_o !== 1'b0 || sync_slow_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: fast=%b slow=%b expected 0 0", sync_fast_o, sync_slow_o);
    end
    model_reset();
    rst = 1'b0;
    m_live = 1'b1;
  endtask

  // Monitor: compare each edge's result against the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      if (m_live && !rst && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_tests++;
        if (sync_fast_o !== e.fast || sync_slow_o !== e.slow) begin
          n_fail++;
          $display("FAIL %s: fast=%b slow=%b expected %0d %0d",
                   e.tag, sync_fast_o, sync_slow_o, e.fast, e.slow);
        end
      end
    end
  end

  initial begin
    model_reset();
    m_live = 1'b0;
    do_reset();
    // R1 R2 R3 R4: defaults after reset, square waves aligned
    idle(2 * S, "R1 R2 R3 R4 defaults");
    // R5 R6 R8: fast narrow, width 5, written mid superframe
    idle(13, "R8 before change");
    tick(1'b1, A_CTRL, 8'h10, "R8 write mode");
    tick(1'b1, A_WIDTH, 8'h05, "R8 write width");
    idle(2 * S, "R5 R6 R8 fast narrow w5");
    // R7: slow narrow with width 0
    tick(1'b1, A_WIDTH, 8'h00, "R7 write width0");
    tick(1'b1, A_CTRL, 8'h20, "R5 write mode10");
    idle(2 * S, "R5 R7 slow narrow w0");
    // R6: both narrow, width 15
    tick(1'b1, A_CTRL, 8'h30, "R5 write mode11");
    tick(1'b1, A_WIDTH, 8'h0F, "R6 write width15");
    idle(2 * S, "R5 R6 both narrow w15");
    // R9: writes to other addresses and data with wr_en low
    tick(1'b1, 5'h05, 8'h00, "R9 stray write");
    tick(1'b1, 5'h11, 8'h01, "R9 stray write");
    tick(1'b0, A_CTRL, 8'h00, "R9 no strobe");
    tick(1'b0, A_WIDTH, 8'h02, "R9 no strobe");
    idle(2 * S, "R9 unchanged");
    // R8: write landing on the last cycle of a superframe waits one more
    while (m_phase != S - 1) tick(1'b0, 5'h00, 8'h00, "R8 align");
    tick(1'b1, A_CTRL, 8'h00, "R8 write at boundary");
    idle(2 * S, "R8 late write");
    // R1: reset in the middle of a run restores defaults
    do_reset();
    idle(S + 5, "R1 R2 R3 after re-reset");
    @(posedge clk); @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule